// File: doc/BRIEF.md
# USB Host Root-Port Suspend/Resume Controller

This block holds the suspend, resume and overcurrent-change state of one USB 2.0 host root port, together with the port state machine that sits behind those bits. Software writes the whole port word in a single strobe. The block carries the enable, suspend, resume-force, port-reset and overcurrent-change fields, and each field follows its own write rule. The bus side provides these inputs:

- a transaction-in-progress level
- a J-to-K transition pulse
- the raw overcurrent level
- a high-speed-idle indication

A suspend request is held pending until any transfer on the wire has finished. While the port is suspended, downstream traffic is blocked and the port listens for wake signalling. A J-to-K edge seen in the suspended state sets the resume bit by hardware and emits a one-cycle port-change pulse. When software clears resume, the bit keeps reading 1 until the bus reports high-speed idle. A cycle counter, derived from the clock frequency, flags a late exit when that idle does not arrive within 2 ms.

The overcurrent level is resynchronised before its edges are detected. Either direction of change sets a sticky change bit, and software clears that bit with write-1-to-clear.

Top module: `psr_port_ctrl`

## Requirements
- R1: After reset every register bit (enable, suspend, resume, port reset, overcurrent change) reads 0, and the port-change pulse, blocked flag, drive-K and late flag are 0.
- R2: port_state_o encodes {enable, suspend}: enable 0 gives 0 (disabled), enable 1 with suspend 0 gives 1 (enabled), enable 1 with suspend 1 gives 2 (suspended).
- R3: A write with the suspend field at 1, on an enabled port not in reset, makes suspend_o read 1 one clock later if xact_busy is low. If xact_busy is high, suspend_o stays 0 until the first edge at which xact_busy is low, and it reads 1 after that edge.
- R4: A write with the suspend field at 0 leaves suspend_o unchanged.
- R5: suspend_o is forced to 0 by a write that takes the port-reset bit from 0 to 1, and by a write that takes the resume bit from 1 to 0.
- R6: blocked_o is 1 exactly when the port is in the suspended state.
- R7: jk_seen high while suspended with resume at 0 sets resume_o and produces pcd_pulse_o for exactly one cycle. A resume set by a software write produces no pulse. jk_seen outside the suspended state has no effect.
- R8: drive_k_o is 1 for as long as resume_o is 1.
- R9: After a write takes resume from 1 to 0, resume_o keeps reading 1 until an edge with hs_idle high, and reads 0 after that edge.
- R10: If hs_idle does not arrive, resume_late_o rises exactly CLK_KHZ*TIMEOUT_US/1000 clocks after the clearing write and falls when the exit completes.
- R11: Each change of oc_in in either direction sets occ_o three clocks later (two synchroniser stages plus the edge register). oc_active_o follows oc_in two clocks later.
- R12: A write with the overcurrent-change field at 1 clears occ_o, a 0 in that field has no effect, and a new overcurrent change in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Port word write strobe |
| wr_enable | input | 1 | Write data: port enable |
| wr_suspend | input | 1 | Write data: suspend (1 requests, 0 ignored) |
| wr_resume | input | 1 | Write data: force resume |
| wr_reset | input | 1 | Write data: port reset |
| wr_occ | input | 1 | Write data: overcurrent change (write-1-to-clear) |
| xact_busy | input | 1 | A transaction is in progress on the bus |
| jk_seen | input | 1 | J-to-K transition detected on the line |
| oc_in | input | 1 | Asynchronous overcurrent-active level |
| hs_idle | input | 1 | Bus below the port has reached high-speed idle |
| enable_o | output | 1 | Enable bit |
| suspend_o | output | 1 | Suspend bit |
| resume_o | output | 1 | Force-resume bit |
| reset_o | output | 1 | Port-reset bit |
| occ_o | output | 1 | Overcurrent-change bit |
| oc_active_o | output | 1 | Synchronised overcurrent level |
| port_state_o | output | 2 | Port state: 0 disabled, 1 enabled, 2 suspended |
| pcd_pulse_o | output | 1 | One-cycle port-change-detect pulse |
| blocked_o | output | 1 | Downstream traffic blocked |
| drive_k_o | output | 1 | Drive resume K on the line |
| resume_late_o | output | 1 | Resume exit overran its time limit |

## Verification
The hardest state to reach is the resume bit held at 1 after software has cleared it. Getting there requires an enabled port, a completed suspend (including one deferred behind a busy transfer), and a wake edge or a software resume. After that, hs_idle has to be withheld for the whole timer window. The stimulus builds that chain with directed writes and runs a shortened timer limit so the late flag can be reached. It then covers the overcurrent path with a seeded random mix of level toggles and clear writes, and each cycle is compared against a bench model of the synchroniser delay.

// File: rtl/psr_pkg.sv
package psr_pkg;
   typedef enum logic [1:0] {
      PS_DISABLED  = 2'd0,
      PS_ENABLED   = 2'd1,
      PS_SUSPENDED = 2'd2
   } psr_state_e;
endpackage

// File: rtl/psr_oc_watch.sv
// Overcurrent level synchroniser with change detection.
module psr_oc_watch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_in,
   output logic oc_level,
   output logic oc_toggle
);
   localparam int TOP = SYNC_STAGES;

   logic [TOP:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[TOP-1:0], oc_in};
   end

   assign oc_level  = stg[TOP-1];
   assign oc_toggle = stg[TOP-1] ^ stg[TOP];
endmodule

// File: rtl/psr_resume_timer.sv
// Counts cycles while a resume exit is pending; flags overrun at LIMIT.
module psr_resume_timer #(
   parameter int LIMIT = 120000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic late
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (cnt != LIM_V) cnt <= cnt + 1'b1;
   end

   assign late = run && (cnt == LIM_V);
endmodule

// File: rtl/psr_susp_core.sv
// Register bits and suspend/resume sequencing of one root port.
module psr_susp_core (
   input  logic clk,
   input  logic rst_n,
   input  logic reg_wr,
   input  logic wr_enable,
   input  logic wr_suspend,
   input  logic wr_resume,
   input  logic wr_reset,
   input  logic xact_busy,
   input  logic jk_seen,
   input  logic hs_idle,
   output logic enable_q,
   output logic suspend_q,
   output logic resume_q,
   output logic reset_q,
   output logic leave_q,
   output logic pcd_q
);
   logic pend_q;
   logic rst_rise, res_fall, res_sw_set, kill;
   logic susp_req, hw_wake, exit_done, want_susp;

   assign rst_rise   = reg_wr && wr_reset && !reset_q;
   assign res_fall   = reg_wr && !wr_resume && resume_q && !leave_q;
   assign res_sw_set = reg_wr && wr_resume && !resume_q && !leave_q;
   assign kill       = rst_rise || res_fall;
   assign susp_req   = reg_wr && wr_suspend && enable_q && !reset_q
                       && !suspend_q && !kill;
   assign want_susp  = !kill && (pend_q || susp_req);
   assign hw_wake    = jk_seen && suspend_q && !resume_q
                       && !(reg_wr && wr_resume) && !kill;
   assign exit_done  = leave_q && hs_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q  <= 1'b0;
         reset_q   <= 1'b0;
         suspend_q <= 1'b0;
         pend_q    <= 1'b0;
         resume_q  <= 1'b0;
         leave_q   <= 1'b0;
         pcd_q     <= 1'b0;
      end else begin
         if (reg_wr) begin
            enable_q <= wr_enable;
            reset_q  <= wr_reset;
         end
         if (kill)                         suspend_q <= 1'b0;
         else if (want_susp && !xact_busy) suspend_q <= 1'b1;
         pend_q <= want_susp && xact_busy;
         if (res_sw_set || hw_wake) resume_q <= 1'b1;
         else if (exit_done)        resume_q <= 1'b0;
         if (res_fall)       leave_q <= 1'b1;
         else if (exit_done) leave_q <= 1'b0;
         pcd_q <= hw_wake;
      end
   end
endmodule

// File: rtl/psr_port_ctrl.sv
module psr_port_ctrl
   import psr_pkg::*;
#(
   parameter int CLK_KHZ     = 60000,
   parameter int TIMEOUT_US  = 2000,
   parameter int SYNC_STAGES = 2,
   parameter bit TIMER_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       wr_enable,
   input  logic       wr_suspend,
   input  logic       wr_resume,
   input  logic       wr_reset,
   input  logic       wr_occ,
   input  logic       xact_busy,
   input  logic       jk_seen,
   input  logic       oc_in,
   input  logic       hs_idle,
   output logic       enable_o,
   output logic       suspend_o,
   output logic       resume_o,
   output logic       reset_o,
   output logic       occ_o,
   output logic       oc_active_o,
   output logic [1:0] port_state_o,
   output logic       pcd_pulse_o,
   output logic       blocked_o,
   output logic       drive_k_o,
   output logic       resume_late_o
);
   localparam int LIMIT = CLK_KHZ * TIMEOUT_US / 1000;

   if (CLK_KHZ < 1)     begin : g_bad_clk  $error("CLK_KHZ must be positive"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be >= 2"); end
   if (LIMIT < 1)       begin : g_bad_lim  $error("timeout window too short"); end

   logic leave_q, oc_tog;
   psr_state_e state;

   psr_susp_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .wr_enable (wr_enable),
      .wr_suspend(wr_suspend),
      .wr_resume (wr_resume),
      .wr_reset  (wr_reset),
      .xact_busy (xact_busy),
      .jk_seen   (jk_seen),
      .hs_idle   (hs_idle),
      .enable_q  (enable_o),
      .suspend_q (suspend_o),
      .resume_q  (resume_o),
      .reset_q   (reset_o),
      .leave_q   (leave_q),
      .pcd_q     (pcd_pulse_o)
   );

   psr_oc_watch #(.SYNC_STAGES(SYNC_STAGES)) u_oc (
      .clk      (clk),
      .rst_n    (rst_n),
      .oc_in    (oc_in),
      .oc_level (oc_active_o),
      .oc_toggle(oc_tog)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 occ_o <= 1'b0;
      else if (oc_tog)            occ_o <= 1'b1;
      else if (reg_wr && wr_occ)  occ_o <= 1'b0;
   end

   if (TIMER_EN) begin : g_timer
      psr_resume_timer #(.LIMIT(LIMIT)) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (leave_q),
         .late (resume_late_o)
      );
   end else begin : g_no_timer
      assign resume_late_o = 1'b0;
   end

   always_comb begin
      if (!enable_o)      state = PS_DISABLED;
      else if (suspend_o) state = PS_SUSPENDED;
      else                state = PS_ENABLED;
   end

   assign port_state_o = state;
   assign blocked_o    = (state == PS_SUSPENDED);
   assign drive_k_o    = resume_o;
endmodule

// File: rtl/psr_port_chk.sv
module psr_port_chk (
   input logic clk,
   input logic rst_n,
   input logic reg_wr,
   input logic wr_reset,
   input logic wr_occ,
   input logic xact_busy,
   input logic jk_seen,
   input logic hs_idle,
   input logic suspend_o,
   input logic resume_o,
   input logic reset_o,
   input logic occ_o,
   input logic pcd_pulse_o,
   input logic blocked_o,
   input logic resume_late_o
);
   // R3
   defer_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blocked_o) |-> $past(!xact_busy));
   // R5
   reset_kills_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && wr_reset && !reset_o) |=> !suspend_o);
   // R7
   pcd_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcd_pulse_o |-> (resume_o && !$past(resume_o) && $past(jk_seen)));
   // R7
   pcd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcd_pulse_o |=> !pcd_pulse_o);
   // R9
   resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resume_o) |-> $past(hs_idle));
   // R10
   late_in_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_late_o |-> resume_o);
   // R12
   occ_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_o && !(reg_wr && wr_occ)) |=> occ_o);
endmodule

bind psr_port_ctrl psr_port_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .wr_reset     (wr_reset),
   .wr_occ       (wr_occ),
   .xact_busy    (xact_busy),
   .jk_seen      (jk_seen),
   .hs_idle      (hs_idle),
   .suspend_o    (suspend_o),
   .resume_o     (resume_o),
   .reset_o      (reset_o),
   .occ_o        (occ_o),
   .pcd_pulse_o  (pcd_pulse_o),
   .blocked_o    (blocked_o),
   .resume_late_o(resume_late_o)
);

// File: tb/sim_psr_port_ctrl.sv
module sim_psr_port_ctrl;
   localparam int PERIOD  = 10;
   localparam int CLK_KHZ = 100;
   localparam int TMO_US  = 2000;
   localparam int LIMIT   = CLK_KHZ * TMO_US / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 0, wr_enable = 0, wr_suspend = 0, wr_resume = 0, wr_reset = 0, wr_occ = 0;
   logic xact_busy = 0, jk_seen = 0, oc_in = 0, hs_idle = 0;
   logic enable_o, suspend_o, resume_o, reset_o, occ_o, oc_active_o;
   logic [1:0] port_state_o;
   logic pcd_pulse_o, blocked_o, drive_k_o, resume_late_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   psr_port_ctrl #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_US(TMO_US)) u0 (.*);

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(bit en, bit su, bit re, bit rs, bit oc);
      reg_wr = 1; wr_enable = en; wr_suspend = su; wr_resume = re; wr_reset = rs; wr_occ = oc;
      step();
      reg_wr = 0; wr_suspend = 0; wr_occ = 0;
   endtask

   function automatic bit occ_next(bit cur, bit chg, bit clr);
      return chg ? 1'b1 : (clr ? 1'b0 : cur);
   endfunction

   initial begin
      repeat (3) step();
      rst_n = 1;
      // R1 reset state
      check("R1 suspend", suspend_o, 0);
      check("R1 resume", resume_o, 0);
      check("R1 occ", occ_o, 0);
      check("R1 enable/reset", {enable_o, reset_o}, 0);
      check("R1 pulses", {pcd_pulse_o, blocked_o, drive_k_o, resume_late_o}, 0);
      check("R2 disabled", port_state_o, 0);

      wr(1, 0, 0, 0, 0);
      check("R2 enabled", port_state_o, 1);
      wr(1, 1, 0, 0, 0);
      check("R3 immediate suspend", suspend_o, 1);
      check("R2 suspended", port_state_o, 2);
      check("R6 blocked", blocked_o, 1);
      wr(1, 0, 0, 0, 0);
      check("R4 write0 ignored", suspend_o, 1);
      wr(1, 0, 0, 1, 0);
      check("R5 reset clears suspend", suspend_o, 0);
      check("R6 unblocked", blocked_o, 0);
      wr(1, 0, 0, 0, 0);

      // R3 deferred behind busy transfer
      xact_busy = 1;
      wr(1, 1, 0, 0, 0);
      check("R3 deferred", suspend_o, 0);
      check("R6 not yet blocked", blocked_o, 0);
      repeat (3) step();
      check("R3 still deferred", suspend_o, 0);
      xact_busy = 0;
      step();
      check("R3 after transfer", suspend_o, 1);

      // R7 hardware wake
      jk_seen = 1;
      step();
      jk_seen = 0;
      check("R7 hw resume", resume_o, 1);
      check("R7 pcd pulse", pcd_pulse_o, 1);
      check("R8 drive k", drive_k_o, 1);
      step();
      check("R7 pcd one cycle", pcd_pulse_o, 0);

      // R9 exit held until high-speed idle
      wr(1, 0, 0, 0, 0);
      check("R5 resume clear kills suspend", suspend_o, 0);
      check("R9 resume held", resume_o, 1);
      repeat (5) step();
      check("R9 resume still held", resume_o, 1);
      check("R8 drive k held", drive_k_o, 1);
      hs_idle = 1;
      step();
      hs_idle = 0;
      check("R9 resume released", resume_o, 0);
      check("R8 drive k off", drive_k_o, 0);

      // R7 software resume gives no pulse; R10 timeout
      wr(1, 1, 0, 0, 0);
      check("R3 resuspend", suspend_o, 1);
      wr(1, 0, 1, 0, 0);
      check("R7 sw resume", resume_o, 1);
      check("R7 no pcd on sw", pcd_pulse_o, 0);
      wr(1, 0, 0, 0, 0);
      repeat (LIMIT - 1) step();
      check("R10 not yet late", resume_late_o, 0);
      step();
      check("R10 late", resume_late_o, 1);
      check("R9 still held when late", resume_o, 1);
      hs_idle = 1;
      step();
      hs_idle = 0;
      check("R10 late clears", resume_late_o, 0);
      check("R9 released", resume_o, 0);

      // R7 J-K outside suspend ignored
      jk_seen = 1;
      step();
      jk_seen = 0;
      check("R7 jk ignored resume", resume_o, 0);
      check("R7 jk ignored pcd", pcd_pulse_o, 0);

      // R11/R12 directed
      oc_in = 1;
      step(); step();
      check("R11 level after 2", oc_active_o, 1);
      check("R11 occ not yet", occ_o, 0);
      step();
      check("R11 occ rise", occ_o, 1);
      wr(1, 0, 0, 0, 0);
      check("R12 write0 keeps", occ_o, 1);
      wr(1, 0, 0, 0, 1);
      check("R12 w1c", occ_o, 0);
      oc_in = 0;
      repeat (3) step();
      check("R11 occ fall edge", occ_o, 1);
      wr(1, 0, 0, 0, 1);
      check("R12 w1c again", occ_o, 0);

      // R11/R12 random mix with model
      begin
         bit p1 = 0, p2 = 0, p3 = 0, exp_occ = 0, clr, chg;
         void'($urandom(32'h5eed_1234));
         for (int i = 0; i < 400; i++) begin
            if ($urandom_range(3) == 0) oc_in = ~oc_in;
            clr = ($urandom_range(4) == 0);
            reg_wr = clr | ($urandom_range(5) == 0);
            wr_enable = 1; wr_suspend = 0; wr_resume = 0; wr_reset = 0;
            wr_occ = clr;
            chg = (p2 != p3);
            exp_occ = occ_next(exp_occ, chg, reg_wr && clr);
            step();
            p3 = p2; p2 = p1; p1 = oc_in;
            check("R11/R12 random occ", occ_o, exp_occ);
            check("R11 random level", oc_active_o, p2);
         end
         reg_wr = 0; wr_occ = 0;
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule